// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the countdown timer of a per-core interrupt controller. Software loads a start value, and the timer counts it down at a rate set by a programmable divider on the bus clock. Each time the count runs out, one expiry is added to a small pending counter. A pending expiry is offered to the core as an interrupt request while the controller is enabled and the timer's vector entry is unmasked. Each accepted request removes one expiry from the counter.

The block holds the six local vector entries. It forwards the timer entry's vector and trigger bit with each request. It also applies the controller-wide enable: turning the controller off masks every entry and drops any expiries that have not been delivered. Priority resolution and register address decode belong to neighbouring logic. That logic drives the write strobes and data here and reads back the current count, the timer entry, the mask bits and the pending count.

Top module: `lict_timer`

## Requirements
- R1: After reset, the current count reads 0 and the pending count reads 0. `irq_valid` is low. All six mask bits read 1. The timer entry reads 0x00010000, which is only its mask bit set. The divide code is 000.
- R2: The divide code is taken as {`div_data`[3], `div_data`[1], `div_data`[0]}, and `div_data`[2] is ignored. The ratio is 2 to the power ((code + 1) mod 8). So 000 gives /2, 001 gives /4, 011 gives /16, 100 gives /32, 110 gives /128 and 111 gives /1.
- R3: A write of N to the start value takes effect at that clock edge. The current count reads N and the divider phase restarts. The count then drops by one every ratio bus cycles, with the first drop ratio cycles after the write.
- R4: A start value of 0 leaves the timer idle. The count stays at 0 and no expiry occurs.
- R5: In one-shot mode (timer entry bit 17 = 0), the tick that takes the count from 1 to 0 adds one expiry. The count then stays at 0.
- R6: In periodic mode (timer entry bit 17 = 1), the tick that finds the count at 1 adds one expiry and reloads the start value. An expiry therefore occurs every N × ratio cycles.
- R7: `irq_valid` is high when the pending count is nonzero, the controller is enabled and timer entry bit 16 (mask) is 0. `irq_vector` is timer entry bits 7:0. A cycle with `irq_valid` and `irq_ack` both high removes one expiry. The pending count saturates at 2^PEND_W − 1.
- R8: A write of the start value clears the pending count.
- R9: Writing 0 to the enable clears the pending count and sets the mask bit of all six entries.
- R10: While the controller is disabled, a write to any entry stores its mask bit as 1, whatever the written data.
- R11: The timer entry keeps only bits 7:0 (vector), 12 (delivery status), 16 (mask) and 17 (periodic), and the other bits read 0. Because the trigger bit (15) is not kept, `irq_level` is always 0. A write to entries 1 to 5 stores only their mask bit (bit 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| init_wr | input | 1 | Start-value write strobe |
| init_data | input | CNT_W | Start value |
| div_wr | input | 1 | Divide-configuration write strobe |
| div_data | input | 4 | Divide configuration |
| lvt_wr | input | 1 | Vector-entry write strobe |
| lvt_sel | input | SEL_W | Entry index, 0 = timer |
| lvt_data | input | 32 | Entry write data |
| en_wr | input | 1 | Enable write strobe |
| en_data | input | 1 | Enable value |
| irq_ack | input | 1 | Core accepts the offered request |
| cur_count | output | CNT_W | Current count |
| timer_lvt | output | 32 | Timer entry readback |
| lvt_mask | output | NUM_LVT | Mask bit of each entry |
| pend_count | output | PEND_W | Undelivered expiries |
| irq_valid | output | 1 | Timer interrupt request |
| irq_vector | output | 8 | Request vector |
| irq_level | output | 1 | Request trigger mode |

## Verification
The bench walks the divide encodings at their extremes: code 111 must give /1 rather than /256, and /128 must not overflow the prescaler. A design that ignored the wrap-around or read bit 2 would land on the wrong count. Periodic reload is checked at the exact tick where the count is 1. A design that lingered at 0 would fall one tick behind and report one expiry too few. Further checks cover saturation of the pending count under back-to-back expiries, masking that blocks the request while expiries stay pending, and disable clearing pending expiries on the same edge where an expiry could arrive. Writes made while disabled must still come back masked.

// File: rtl/lict_pkg.sv
package lict_pkg;
    localparam int LVT_W      = 32;
    localparam int VEC_W      = 8;
    localparam int CODE_W     = 3;
    localparam int PSC_W      = (1 << CODE_W) - 1;
    localparam int BIT_DSTAT  = 12;
    localparam int BIT_TRIG   = 15;
    localparam int BIT_MASK   = 16;
    localparam int BIT_PER    = 17;
    localparam logic [LVT_W-1:0] TIMER_KEEP = 32'h0003_10FF;
    localparam logic [LVT_W-1:0] TIMER_RST  = 32'h0001_0000;

    function automatic logic [CODE_W-1:0] div_shift(input logic [CODE_W-1:0] code);
        return code + 1'b1;
    endfunction
endpackage

// File: rtl/lict_prescaler.sv
module lict_prescaler
    import lict_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [PSC_W-1:0] psc;
    } psc_st_t;

    psc_st_t st_d, st_q;
    logic [PSC_W:0]   ratio;
    logic [PSC_W-1:0] limit;

    always_comb begin
        ratio  = (PSC_W+1)'(1) << div_shift(code_i);
        limit  = PSC_W'(ratio - 1'b1);
        st_d   = st_q;
        tick_o = 1'b0;
        if (restart_i) begin
            st_d.psc = '0;
        end else if (st_q.psc >= limit) begin
            tick_o   = 1'b1;
            st_d.psc = '0;
        end else begin
            st_d.psc = st_q.psc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PSC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !tick_o) |=> st_q.psc == $past(st_q.psc) + 1'b1); // R3
endmodule

// File: rtl/lict_counter.sv
module lict_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic             tick_i,
    input  logic             periodic_i,
    output logic [CNT_W-1:0] cur_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] start;
        logic [CNT_W-1:0] cur;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (restart_i) begin
            st_d.start = load_i;
            st_d.cur   = load_i;
        end else if (tick_i && st_q.cur != '0) begin
            if (st_q.cur == CNT_W'(1)) begin
                expire_o = 1'b1;
                st_d.cur = periodic_i ? st_q.start : '0;
            end else begin
                st_d.cur = st_q.cur - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_o = st_q.cur;

    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cur == '0 && !restart_i) |=> st_q.cur == '0); // R4
    AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !restart_i && st_q.cur > CNT_W'(1)) |=> st_q.cur == $past(st_q.cur) - 1'b1); // R3
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !periodic_i) |=> st_q.cur == '0); // R5
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && periodic_i) |=> st_q.cur == st_q.start); // R6
endmodule

// File: rtl/lict_lvt_bank.sv
module lict_lvt_bank
    import lict_pkg::*;
#(
    parameter int NUM_LVT = 6,
    parameter int SEL_W   = $clog2(NUM_LVT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [LVT_W-1:0]   data_i,
    input  logic               en_i,
    input  logic               dis_i,
    output logic [LVT_W-1:0]   timer_o,
    output logic [NUM_LVT-1:0] mask_o
);
    typedef struct packed {
        logic [LVT_W-1:0]   tmr;
        logic [NUM_LVT-1:1] msk;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     wr_mask;

    always_comb begin
        st_d    = st_q;
        wr_mask = data_i[BIT_MASK] | ~en_i;
        if (wr_i) begin
            if (sel_i == '0) begin
                st_d.tmr           = data_i & TIMER_KEEP;
                st_d.tmr[BIT_MASK] = wr_mask;
            end
            for (int i = 1; i < NUM_LVT; i++) begin
                if (sel_i == SEL_W'(i)) st_d.msk[i] = wr_mask;
            end
        end
        if (dis_i) begin
            st_d.tmr[BIT_MASK] = 1'b1;
            st_d.msk           = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tmr <= TIMER_RST;
            st_q.msk <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign timer_o = st_q.tmr;

    generate
        for (genvar g = 0; g < NUM_LVT; g++) begin : g_mask
            if (g == 0) begin : g_tmr
                assign mask_o[g] = st_q.tmr[BIT_MASK];
            end else begin : g_other
                assign mask_o[g] = st_q.msk[g];
            end
        end
    endgenerate

    AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |=> (&mask_o)); // R9
    AST_WR_DISABLED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !en_i && sel_i < SEL_W'(NUM_LVT)) |=> mask_o[$past(sel_i)]); // R10
endmodule

// File: rtl/lict_timer.sv
module lict_timer
    import lict_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int PEND_W  = 4,
    parameter int NUM_LVT = 6,
    parameter int SEL_W   = $clog2(NUM_LVT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_wr,
    input  logic [CNT_W-1:0]   init_data,
    input  logic               div_wr,
    input  logic [3:0]         div_data,
    input  logic               lvt_wr,
    input  logic [SEL_W-1:0]   lvt_sel,
    input  logic [LVT_W-1:0]   lvt_data,
    input  logic               en_wr,
    input  logic               en_data,
    input  logic               irq_ack,
    output logic [CNT_W-1:0]   cur_count,
    output logic [LVT_W-1:0]   timer_lvt,
    output logic [NUM_LVT-1:0] lvt_mask,
    output logic [PEND_W-1:0]  pend_count,
    output logic               irq_valid,
    output logic [VEC_W-1:0]   irq_vector,
    output logic               irq_level
);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
        logic [PEND_W-1:0] pend;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    tick, expire, dis, deliver;
    logic    unused_div;

    assign unused_div = div_data[2];
    assign dis        = en_wr & ~en_data;
    assign irq_valid  = st_q.en & ~timer_lvt[BIT_MASK] & (st_q.pend != '0);
    assign deliver    = irq_valid & irq_ack;

    always_comb begin
        st_d = st_q;
        if (en_wr)  st_d.en   = en_data;
        if (div_wr) st_d.code = {div_data[3], div_data[1:0]};
        if (init_wr || dis) begin
            st_d.pend = '0;
        end else if (expire && !deliver) begin
            if (st_q.pend != PEND_MAX) st_d.pend = st_q.pend + 1'b1;
        end else if (deliver && !expire) begin
            st_d.pend = st_q.pend - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    lict_prescaler u_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (init_wr),
        .code_i    (st_q.code),
        .tick_o    (tick)
    );

    lict_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (init_wr),
        .load_i     (init_data),
        .tick_i     (tick),
        .periodic_i (timer_lvt[BIT_PER]),
        .cur_o      (cur_count),
        .expire_o   (expire)
    );

    lict_lvt_bank #(.NUM_LVT(NUM_LVT), .SEL_W(SEL_W)) u_lvt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (lvt_wr),
        .sel_i   (lvt_sel),
        .data_i  (lvt_data),
        .en_i    (st_q.en),
        .dis_i   (dis),
        .timer_o (timer_lvt),
        .mask_o  (lvt_mask)
    );

    assign pend_count = st_q.pend;
    assign irq_vector = timer_lvt[VEC_W-1:0];
    assign irq_level  = timer_lvt[BIT_TRIG];

    AST_INIT_CLR_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> pend_count == '0); // R8
    AST_PEND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !deliver && !init_wr && !dis && pend_count != PEND_MAX)
        |=> pend_count == $past(pend_count) + 1'b1); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_count == PEND_MAX && !deliver && !init_wr && !dis) |=> pend_count == PEND_MAX); // R7
    AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !irq_level); // R11
endmodule

// File: tb/lict_timer_tb_top.sv
`timescale 1ns/1ps
module lict_timer_tb_top;
    localparam int CNT_W = 32;
    localparam int PEND_W = 4;
    localparam int NUM_LVT = 6;
    localparam int SEL_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_wr = 1'b0;
    logic [CNT_W-1:0] init_data = '0;
    logic div_wr = 1'b0;
    logic [3:0] div_data = '0;
    logic lvt_wr = 1'b0;
    logic [SEL_W-1:0] lvt_sel = '0;
    logic [31:0] lvt_data = '0;
    logic en_wr = 1'b0;
    logic en_data = 1'b0;
    logic irq_ack = 1'b0;
    logic [CNT_W-1:0] cur_count;
    logic [31:0] timer_lvt;
    logic [NUM_LVT-1:0] lvt_mask;
    logic [PEND_W-1:0] pend_count;
    logic irq_valid;
    logic [7:0] irq_vector;
    logic irq_level;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    lict_timer #(.CNT_W(CNT_W), .PEND_W(PEND_W), .NUM_LVT(NUM_LVT), .SEL_W(SEL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .init_wr(init_wr), .init_data(init_data),
        .div_wr(div_wr), .div_data(div_data), .lvt_wr(lvt_wr), .lvt_sel(lvt_sel),
        .lvt_data(lvt_data), .en_wr(en_wr), .en_data(en_data), .irq_ack(irq_ack),
        .cur_count(cur_count), .timer_lvt(timer_lvt), .lvt_mask(lvt_mask),
        .pend_count(pend_count), .irq_valid(irq_valid), .irq_vector(irq_vector),
        .irq_level(irq_level)
    );

    typedef struct packed {
        logic [3:0]  dv;
        logic [31:0] start;
        logic        per;
        logic [15:0] wait_n;
        logic [31:0] exp_cur;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{dv: 4'hB, start: 32'd10, per: 1'b0, wait_n: 16'd4,   exp_cur: 32'd6},
        '{dv: 4'h0, start: 32'd10, per: 1'b0, wait_n: 16'd5,   exp_cur: 32'd8},
        '{dv: 4'h1, start: 32'd20, per: 1'b0, wait_n: 16'd9,   exp_cur: 32'd18},
        '{dv: 4'h4, start: 32'd7,  per: 1'b0, wait_n: 16'd6,   exp_cur: 32'd4},
        '{dv: 4'h8, start: 32'd5,  per: 1'b0, wait_n: 16'd70,  exp_cur: 32'd3},
        '{dv: 4'hA, start: 32'd3,  per: 1'b0, wait_n: 16'd130, exp_cur: 32'd2},
        '{dv: 4'h3, start: 32'd2,  per: 1'b0, wait_n: 16'd40,  exp_cur: 32'd0},
        '{dv: 4'hB, start: 32'd4,  per: 1'b1, wait_n: 16'd6,   exp_cur: 32'd2},
        '{dv: 4'h0, start: 32'd3,  per: 1'b1, wait_n: 16'd13,  exp_cur: 32'd3},
        '{dv: 4'hB, start: 32'd0,  per: 1'b0, wait_n: 16'd5,   exp_cur: 32'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic wr_init(input logic [31:0] v);
        @(negedge clk); init_wr = 1'b1; init_data = v;
        @(negedge clk); init_wr = 1'b0;
    endtask

    task automatic wr_div(input logic [3:0] v);
        @(negedge clk); div_wr = 1'b1; div_data = v;
        @(negedge clk); div_wr = 1'b0;
    endtask

    task automatic wr_lvt(input logic [2:0] s, input logic [31:0] v);
        @(negedge clk); lvt_wr = 1'b1; lvt_sel = s; lvt_data = v;
        @(negedge clk); lvt_wr = 1'b0;
    endtask

    task automatic wr_en(input logic v);
        @(negedge clk); en_wr = 1'b1; en_data = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cur", cur_count, 0);
        chk("R1 pend", 32'(pend_count), 0);
        chk("R1 irq", 32'(irq_valid), 0);
        chk("R1 masks", 32'(lvt_mask), 32'h3F);
        chk("R1 timer entry", timer_lvt, 32'h0001_0000);
        // R1 R2 default divide is /2
        wr_init(32'd4);
        wait_edges(3);
        chk("R1 R2 default divide", cur_count, 32'd3);

        // R2 R3 R4 R6 table walk
        for (int i = 0; i < NV; i++) begin
            wr_div(TBL[i].dv);
            wr_lvt(3'd0, TBL[i].per ? 32'h0003_0000 : 32'h0001_0000);
            wr_init(TBL[i].start);
            wait_edges(int'(TBL[i].wait_n));
            chk($sformatf("R2 R3 R6 vector %0d", i), cur_count, TBL[i].exp_cur);
        end

        // R10 write while disabled comes back masked
        wr_lvt(3'd0, 32'h0000_0033);
        chk("R10 timer forced mask", timer_lvt, 32'h0001_0033);
        wr_lvt(3'd3, 32'h0);
        chk("R10 entry 3 forced mask", 32'(lvt_mask), 32'h3F);

        // R11 kept bits of timer entry
        wr_en(1'b1);
        wr_lvt(3'd0, 32'hFFFF_FFFF);
        chk("R11 timer kept bits", timer_lvt, 32'h0003_10FF);
        chk("R11 trigger low", 32'(irq_level), 0);

        // R5 one-shot expiry, R7 delivery
        wr_div(4'hB);
        wr_lvt(3'd0, 32'h0000_0045);
        wr_init(32'd3);
        wait_edges(3);
        chk("R5 count at zero", cur_count, 0);
        chk("R5 one expiry", 32'(pend_count), 1);
        chk("R7 request raised", 32'(irq_valid), 1);
        chk("R7 vector", 32'(irq_vector), 32'h45);
        wait_edges(5);
        chk("R5 stays stopped", cur_count, 0);
        chk("R5 no further expiry", 32'(pend_count), 1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk("R7 ack removes expiry", 32'(pend_count), 0);
        chk("R7 request drops", 32'(irq_valid), 0);

        // R6 periodic accumulation, R8 restart clears pending
        wr_lvt(3'd0, 32'h0002_0045);
        wr_init(32'd2);
        wait_edges(6);
        chk("R6 three expiries", 32'(pend_count), 3);
        wr_init(32'd1);
        chk("R8 init clears pending", 32'(pend_count), 0);
        wait_edges(20);
        chk("R7 saturation", 32'(pend_count), 15);

        // R7 mask blocks request
        wr_lvt(3'd0, 32'h0003_0045);
        chk("R7 masked no request", 32'(irq_valid), 0);
        chk("R7 masked keeps pending", 32'(pend_count), 15);
        wr_lvt(3'd0, 32'h0002_0045);
        chk("R7 unmasked request", 32'(irq_valid), 1);

        // R9 disable
        wr_lvt(3'd3, 32'h0);
        chk("R9 entry 3 unmasked first", 32'(lvt_mask[3]), 0);
        wr_en(1'b0);
        chk("R9 all masked", 32'(lvt_mask), 32'h3F);
        chk("R9 pending cleared", 32'(pend_count), 0);
        chk("R9 no request", 32'(irq_valid), 0);

        // R4 zero start value idles
        wr_init(32'd0);
        wait_edges(10);
        chk("R4 idle count", cur_count, 0);
        chk("R4 no expiry", 32'(pend_count), 0);

        finish_up();
    end
endmodule